// File: doc/BRIEF.md
# Byte-Pairing Word Write Interface

This block accepts byte writes from a byte-wide table-write port and turns them into write cycles on a 16-bit word-wide external memory. The memory sits behind a multiplexed address/data bus. Each request carries a byte address and one data byte. Bit 0 of the byte address decides what happens. An even address parks the byte in an internal holding register. The bus cycle for an even address still presents the address, but the data lines float and no strobe fires. An odd address runs a full write cycle. The new byte goes on the upper half of the bus and the parked byte on the lower half. One write-high strobe fires, and both byte selects are active.

Every request, even or odd, runs the same fixed sequence of one-clock phases: address with the latch enable high, address held with the latch enable low, data, then release. The requester sees a ready signal, and ready stays low until the sequence has finished. The word address (byte address bits 20:1) goes out in two parts. Its low 16 bits share the data lines and its top bits have their own port. The byte-address bit is also driven out, but it never gates a write. To write a word correctly, the user issues the even byte and then the odd byte of the same word.

Top module: `word_pair_writer`

## Requirements
- R1: After reset, `req_ready`=1 and `ale`=0, `ad_oe`=0, and `wrh_n`, `wrl_n`, `oe_n`, `ub_n`, `lb_n` are all 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly four clock cycles and returns to 1 on the fifth.
- R3: On the second cycle after the accepting edge, `ale`=1 and `ad_oe`=1. In that cycle `ad_out` carries byte-address bits 16:1, `addr_hi` carries bits 20:17 and `ba0` carries bit 0. In the next cycle `ale`=0 and the same address is still driven.
- R4: For an even address (bit 0 = 0), the data phase (fourth cycle after acceptance) has `ad_oe`=0, and `wrh_n`, `ub_n` and `lb_n` all stay 1. The data byte is stored in the holding register.
- R5: For an odd address (bit 0 = 1), the data phase has `ad_oe`=1 and `ad_out` = {request byte, holding byte}, with the request byte in bits 15:8. In that phase `wrh_n`=0 for exactly one cycle and `ub_n`=`lb_n`=0. Every odd request produces exactly one strobe.
- R6: `wrl_n` and `oe_n` are 1 in every cycle.
- R7: The cycle after the data phase is a release phase: `ad_oe`=0 and `wrh_n`, `ub_n` and `lb_n` are 1.
- R8: An odd write does not change the holding register. Two odd writes with no even write between them use the same low byte.
- R9: An odd write issued after reset with no earlier even write uses 0x00 as the low byte. No error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Byte write request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W (21) | Byte address |
| req_data | input | BYTE_W (8) | Byte to write |
| ad_out | output | 2*BYTE_W (16) | Multiplexed address/data lines |
| ad_oe | output | 1 | Drive enable for `ad_out` (0 = tri-stated) |
| addr_hi | output | ADDR_W-1-2*BYTE_W (4) | Upper word-address bits |
| ale | output | 1 | Address latch enable |
| ba0 | output | 1 | Byte-address bit 0 of the current cycle |
| oe_n | output | 1 | Read output enable, active low |
| wrh_n | output | 1 | Write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, unused (held 1) |
| ub_n | output | 1 | Upper byte select, active low |
| lb_n | output | 1 | Lower byte select, active low |

## Verification
If the holding register holds the wrong value, the low byte of the next odd-cycle data phase is wrong. That shows up four cycles after the odd request is accepted. If the phase sequencer is wrong, a strobe fires on an even cycle, data is driven while it should float, the latch pulse is missing, or the ready low time is not four cycles. Each of these shows within one request. The bench keeps an expected queue of bus cycles and compares every phase of every cycle. At the end it also compares the total strobe count with the number of odd requests.

// File: rtl/wpw_pkg.sv
package wpw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_DATA = 3'd3,
    PH_REL  = 3'd4
  } phase_t;
endpackage

// File: rtl/wpw_seq.sv
module wpw_seq
  import wpw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   idle
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) phase_q <= PH_ADDR;
        PH_ADDR: phase_q <= PH_HOLD;
        PH_HOLD: phase_q <= PH_DATA;
        PH_DATA: phase_q <= PH_REL;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
  assign idle  = (phase_q == PH_IDLE);
endmodule

// File: rtl/wpw_hold.sv
module wpw_hold #(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [BYTE_W-1:0]   data_in,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                cur_odd,
  output logic [2*BYTE_W-1:0] cur_word
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      cur_addr <= '0;
      cur_odd  <= 1'b0;
      cur_word <= '0;
    end else if (start) begin
      cur_addr <= addr_in;
      cur_odd  <= addr_in[0];
      if (addr_in[0]) begin
        cur_word <= {data_in, hold_q};
      end else begin
        hold_q   <= data_in;
      end
    end
  end
endmodule

// File: rtl/wpw_pins.sv
module wpw_pins
  import wpw_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  phase_t                            phase,
  input  logic [ADDR_W-1:0]                 cur_addr,
  input  logic                              cur_odd,
  input  logic [2*BYTE_W-1:0]               cur_word,
  output logic [2*BYTE_W-1:0]               ad_out,
  output logic                              ad_oe,
  output logic [ADDR_W-1-2*BYTE_W-1:0]      addr_hi,
  output logic                              ale,
  output logic                              ba0,
  output logic                              wrh_n,
  output logic                              ub_n,
  output logic                              lb_n
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int HI_W   = ADDR_W - 1 - WORD_W;

  logic [WORD_W-1:0] waddr_lo;
  logic [HI_W-1:0]   waddr_hi;
  logic [WORD_W-1:0] ad_d;
  logic [HI_W-1:0]   hi_d;
  logic              oe_d, ale_d, ba0_d, wrh_d, sel_d;

  assign waddr_lo = cur_addr[WORD_W:1];
  assign waddr_hi = cur_addr[ADDR_W-1:WORD_W+1];

  always_comb begin
    ad_d  = '0;
    hi_d  = '0;
    oe_d  = 1'b0;
    ale_d = 1'b0;
    ba0_d = 1'b0;
    wrh_d = 1'b1;
    sel_d = 1'b1;
    case (phase)
      PH_ADDR: begin
        ad_d = waddr_lo; hi_d = waddr_hi; oe_d = 1'b1; ale_d = 1'b1; ba0_d = cur_addr[0];
      end
      PH_HOLD: begin
        ad_d = waddr_lo; hi_d = waddr_hi; oe_d = 1'b1; ba0_d = cur_addr[0];
      end
      PH_DATA: begin
        hi_d = waddr_hi; ba0_d = cur_addr[0];
        if (cur_odd) begin
          ad_d = cur_word; oe_d = 1'b1; wrh_d = 1'b0; sel_d = 1'b0;
        end
      end
      PH_REL: begin
        hi_d = waddr_hi; ba0_d = cur_addr[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out  <= '0;
      addr_hi <= '0;
      ad_oe   <= 1'b0;
      ale     <= 1'b0;
      ba0     <= 1'b0;
      wrh_n   <= 1'b1;
      ub_n    <= 1'b1;
      lb_n    <= 1'b1;
    end else begin
      ad_out  <= ad_d;
      addr_hi <= hi_d;
      ad_oe   <= oe_d;
      ale     <= ale_d;
      ba0     <= ba0_d;
      wrh_n   <= wrh_d;
      ub_n    <= sel_d;
      lb_n    <= sel_d;
    end
  end
endmodule

// File: rtl/word_pair_writer.sv
module word_pair_writer
  import wpw_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [BYTE_W-1:0]            req_data,
  output logic [2*BYTE_W-1:0]          ad_out,
  output logic                         ad_oe,
  output logic [ADDR_W-1-2*BYTE_W-1:0] addr_hi,
  output logic                         ale,
  output logic                         ba0,
  output logic                         oe_n,
  output logic                         wrh_n,
  output logic                         wrl_n,
  output logic                         ub_n,
  output logic                         lb_n
);
  localparam int WORD_W = 2 * BYTE_W;

  phase_t            phase;
  logic              start;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_odd;
  logic [WORD_W-1:0] cur_word;

  assign start = req_valid && req_ready;
  assign oe_n  = 1'b1;
  assign wrl_n = 1'b1;

  wpw_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .phase (phase),
    .idle  (req_ready)
  );

  wpw_hold #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .addr_in  (req_addr),
    .data_in  (req_data),
    .cur_addr (cur_addr),
    .cur_odd  (cur_odd),
    .cur_word (cur_word)
  );

  wpw_pins #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .cur_addr (cur_addr),
    .cur_odd  (cur_odd),
    .cur_word (cur_word),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .addr_hi  (addr_hi),
    .ale      (ale),
    .ba0      (ba0),
    .wrh_n    (wrh_n),
    .ub_n     (ub_n),
    .lb_n     (lb_n)
  );
endmodule

// File: rtl/wpw_checker.sv
module wpw_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic ad_oe,
  input logic wrh_n,
  input logic ub_n,
  input logic lb_n
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> wrh_n && !ale); // R2
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale && ad_oe); // R3
  AST_ALE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe); // R3
  AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (rst)
    !wrh_n |-> ad_oe && !ub_n && !lb_n); // R5
  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !wrh_n |=> wrh_n && !ad_oe && ub_n && lb_n); // R7
endmodule

bind word_pair_writer wpw_checker u_chk (.*);

// File: tb/word_pair_writer_test.sv
`timescale 1ns/1ps
module word_pair_writer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  addr_hi;
  logic        ale, ba0, oe_n, wrh_n, wrl_n, ub_n, lb_n;

  typedef struct packed {
    logic        odd;
    logic [20:0] addr;
    logic [15:0] word;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   vectors = 0;
  int   fails = 0;
  int   mon_ph = 0;
  int   strobes = 0;
  int   odd_sent = 0;
  logic [7:0] hold_m = 8'h00;
  bit   done = 0;

  always #2.5 clk = ~clk;

  word_pair_writer uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [20:0] a, input logic [7:0] d);
    exp_t e;
    int n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    e.odd = a[0]; e.addr = a;
    if (a[0]) begin
      e.word = {d, hold_m};
      odd_sent++;
    end else begin
      e.word = 16'h0;
      hold_m = d;
    end
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == 4, "R2 ready low cycles", n, 4);
  endtask

  // Monitor: compares each bus phase against the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (!wrh_n) strobes++;
      if (!wrl_n || !oe_n) chk(0, "R6 wrl_n/oe_n", {wrl_n, oe_n}, 2'b11);
      case (mon_ph)
        0: if (ale) begin
             if (exp_q.size() == 0) begin
               chk(0, "R3 unexpected cycle", ad_out, 0);
             end else begin
               cur = exp_q.pop_front();
               chk(ad_oe && ad_out == cur.addr[16:1] && addr_hi == cur.addr[20:17] && ba0 == cur.addr[0],
                   "R3 address phase", {ad_oe, addr_hi, ad_out, ba0}, {1'b1, cur.addr[20:17], cur.addr[16:1], cur.addr[0]});
               mon_ph = 1;
             end
           end
        1: begin
             chk(!ale && ad_oe && ad_out == cur.addr[16:1], "R3 hold phase",
                 {ale, ad_oe, ad_out}, {2'b01, cur.addr[16:1]});
             mon_ph = 2;
           end
        2: begin
             if (cur.odd)
               chk(ad_oe && ad_out == cur.word && !wrh_n && !ub_n && !lb_n, "R5 R8 R9 odd data phase",
                   {ad_oe, wrh_n, ub_n, lb_n, ad_out}, {4'b1000, cur.word});
             else
               chk(!ad_oe && wrh_n && ub_n && lb_n, "R4 even data phase",
                   {ad_oe, wrh_n, ub_n, lb_n}, 4'b0111);
             mon_ph = 3;
           end
        default: begin
             chk(!ad_oe && wrh_n && ub_n && lb_n, "R7 release phase",
                 {ad_oe, wrh_n, ub_n, lb_n}, 4'b0111);
             mon_ph = 0;
           end
      endcase
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !ale && !ad_oe && wrh_n && wrl_n && oe_n && ub_n && lb_n, "R1 reset state",
        {req_ready, ale, ad_oe, wrh_n, wrl_n, oe_n, ub_n, lb_n}, 8'b10011111);
    do_write(21'h000101, 8'hA5);   // R9: low byte 0x00
    do_write(21'h000200, 8'h34);   // R4
    do_write(21'h000201, 8'h12);   // R5
    do_write(21'h000203, 8'h56);   // R8: reuses 0x34
    do_write(21'h1FFFFE, 8'hEF);
    do_write(21'h1FFFFF, 8'hBE);
    do_write(21'h000000, 8'h01);
    do_write(21'h000000, 8'h02);   // even overwrite
    do_write(21'h000001, 8'h03);
    for (int i = 1; i < 7; i++) begin
      do_write(21'(i * 21'h24682), 8'(i * 17));
      do_write(21'(i * 21'h24682 + 1), 8'(8'hF0 - i));
    end
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0 && mon_ph == 0, "R3 all cycles seen", exp_q.size(), 0);
    chk(strobes == odd_sent, "R5 strobe count", strobes, odd_sent);
    chk(req_ready && !ad_oe && wrh_n, "R7 idle after run", {req_ready, ad_oe, wrh_n}, 3'b101);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule